// File: doc/BRIEF.md
# Asynchronous-Strobe to Byte-Lane Bus Bridge

This block connects a 16-bit processor bus that completes each transfer by handshake (an address strobe, two data strobes and an acknowledge returned to the processor) to a clocked system bus whose byte strobes are numbered by address offset. The processor's address strobe is brought into the system clock domain through a short synchroniser. A three-state cycle controller then runs one system transfer per processor cycle. It raises write byte strobes or a read strobe, waits for the system's ready signal and answers the processor with an acknowledge. The acknowledge stays asserted until the processor drops its address strobe.

The processor is big-endian and the system bus is not. The even byte travels on the processor's upper half under the upper data strobe, and that byte belongs in system lane 0. The bridge therefore crosses the two byte lanes in both directions. Processor and system data use separate input and output buses, each with an enable per lane, and a lane is only driven when the processor has asked for it. If ready never comes, the processor waits forever: the bridge raises no timeout.

Top module: `laneBridge`

## Requirements
- R1: `sysAddr[23:1]` equals `cpuAddr[22:0]` and `sysAddr[0]` is always 0.
- R2: A fall of `cpuAddrStbN` reaches the controller through two flip-flops. When the strobe is set up before rising edge k, the transfer strobes first appear after edge k+2. After the strobe rises, the acknowledge is released after the third rising edge.
- R3: In the ACTIVE state the controller stays in ACTIVE for as long as `sysReady` is low, with no limit, and `cpuAckN` stays high. A high `sysReady` in ACTIVE moves the controller to DONE on the next edge.
- R4: `cpuAckN` is low only in the DONE state (encoding 2'b11). DONE is held until the synchronised address strobe is high again, and the controller then returns to IDLE.
- R5: `sysWrStb[0]` = ACTIVE and write (`cpuRdWr`=0) and `cpuUpperStbN` low. `sysWrStb[1]` = ACTIVE and write and `cpuLowerStbN` low. Neither is asserted in DONE.
- R6: `sysRdStb` = cycle in progress (ACTIVE or DONE) and read (`cpuRdWr`=1) and at least one data strobe low. An address strobe with neither data strobe low produces no transfer strobe.
- R7: The lanes are crossed. `sysDataOut[7:0]` carries `cpuDataIn[15:8]` and `sysDataOut[15:8]` carries `cpuDataIn[7:0]`. `cpuDataOut[15:8]` carries `sysDataIn[7:0]` and `cpuDataOut[7:0]` carries `sysDataIn[15:8]`.
- R8: A lane is enabled only while a cycle is in progress and that lane's own data strobe is low. The system lanes are enabled on writes (`sysDataOutEn[0]` is the upper strobe, `[1]` the lower). The processor lanes are enabled on reads (`cpuDataOutEn[1]` is the upper half, `[0]` the lower half). A disabled lane outputs zero.
- R9: A byte write of 0xAB to byte address 0x3000, then a byte write of 0xCD to 0x3001, then a word read at 0x3000 returns 0xABCD to the processor.
- R10: Synchronous reset (`rst` high) puts the controller in IDLE and presets both synchroniser flops high. After reset `cpuAckN` is high and no strobe or enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuAddr | input | 23 | Processor word address A[23:1] |
| cpuRdWr | input | 1 | 1 = read, 0 = write |
| cpuAddrStbN | input | 1 | Address strobe, active low |
| cpuUpperStbN | input | 1 | Upper (even byte) data strobe, active low |
| cpuLowerStbN | input | 1 | Lower (odd byte) data strobe, active low |
| cpuDataIn | input | 16 | Write data from the processor |
| cpuDataOut | output | 16 | Read data to the processor |
| cpuDataOutEn | output | 2 | Processor lane drive enables, bit 1 = D[15:8] |
| cpuAckN | output | 1 | Data acknowledge, active low |
| sysAddr | output | 24 | System byte address |
| sysDataOut | output | 16 | System write data |
| sysDataOutEn | output | 2 | System lane drive enables, bit i = lane i |
| sysDataIn | input | 16 | System read data |
| sysWrStb | output | 2 | Write byte strobes, bit i = byte at offset i |
| sysRdStb | output | 1 | Read strobe |
| sysReady | input | 1 | Transfer complete from the system side |

## Verification
The hardest situation to reach is a controller parked in ACTIVE with no ready for a long stretch. The acknowledge must stay withheld and the write strobe must stay steady the whole time. The bench reaches this by switching its memory model's ready response off before it starts a cycle. It counts the two synchroniser edges to find the exact cycle in which the strobes appear, holds there for twenty cycles, and only then lets ready through. An address strobe given with neither data strobe low is reached the same way. It must produce no transfer and no acknowledge.

// File: rtl/laneBridgePkg.sv
package laneBridgePkg;

  localparam int LANES  = 2;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    CYC_IDLE   = 2'b00,
    CYC_ACTIVE = 2'b01,
    CYC_DONE   = 2'b11
  } cycState_t;

  typedef struct packed {
    logic             busy;     // ACTIVE or DONE
    logic             wrPhase;  // ACTIVE and write
    logic             rdPhase;  // busy and read
    logic             wrDrive;  // busy and write
    logic [LANES-1:0] laneSel;  // requested lanes, system order
  } laneCtl_t;

endpackage

// File: rtl/bridgeCtrl.sv
module bridgeCtrl
  import laneBridgePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cpuAddrStbN,
  input  logic     cpuUpperStbN,
  input  logic     cpuLowerStbN,
  input  logic     cpuRdWr,
  input  logic     sysReady,
  output laneCtl_t ctl,
  output logic     cpuAckN
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] stbSync;
  logic                   stbLowSync;
  cycState_t              state;
  cycState_t              stateNext;

  // Synchroniser, preset high (deasserted) in reset.
  always_ff @(posedge clk) begin
    if (rst) stbSync <= '1;
    else     stbSync <= {stbSync[SYNC_STAGES-2:0], cpuAddrStbN};
  end

  assign stbLowSync = ~stbSync[LAST];

  always_comb begin
    stateNext = state;
    unique case (state)
      CYC_IDLE:   if (stbLowSync) stateNext = CYC_ACTIVE;
      CYC_ACTIVE: if (sysReady)   stateNext = CYC_DONE;
      CYC_DONE:   if (!stbLowSync) stateNext = CYC_IDLE;
      default:    stateNext = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= CYC_IDLE;
    else     state <= stateNext;
  end

  logic inActive;
  logic busy;
  logic [LANES-1:0] laneReq;

  assign inActive = (state == CYC_ACTIVE);
  assign busy     = (state != CYC_IDLE);

  // System lane 0 is the even byte (upper strobe), lane 1 the odd byte.
  assign laneReq = {~cpuLowerStbN, ~cpuUpperStbN};

  always_comb begin
    ctl.busy    = busy;
    ctl.wrPhase = inActive & ~cpuRdWr;
    ctl.rdPhase = busy & cpuRdWr;
    ctl.wrDrive = busy & ~cpuRdWr;
    ctl.laneSel = laneReq;
  end

  assign cpuAckN = ~(state == CYC_DONE);

  // R3: without ready the controller never leaves ACTIVE
  a_r3_wait_for_ready: assert property (@(posedge clk) disable iff (rst)
    (state == CYC_ACTIVE && !sysReady) |=> (state == CYC_ACTIVE));

  // R2: no cycle starts while the synchronised strobe is high
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (state == CYC_IDLE && stbSync[LAST]) |=> (state == CYC_IDLE));

  // R4: DONE persists until the synchronised strobe rises
  a_r4_done_holds: assert property (@(posedge clk) disable iff (rst)
    (state == CYC_DONE && !stbSync[LAST]) |=> (state == CYC_DONE));

endmodule

// File: rtl/bridgeDatapath.sv
module bridgeDatapath
  import laneBridgePkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  laneCtl_t                  ctl,
  input  logic [ADDR_W-2:0]         cpuAddr,
  input  logic [LANES*LANE_W-1:0]   cpuDataIn,
  output logic [LANES*LANE_W-1:0]   cpuDataOut,
  output logic [LANES-1:0]          cpuDataOutEn,
  output logic [ADDR_W-1:0]         sysAddr,
  output logic [LANES*LANE_W-1:0]   sysDataOut,
  output logic [LANES-1:0]          sysDataOutEn,
  input  logic [LANES*LANE_W-1:0]   sysDataIn,
  output logic [LANES-1:0]          sysWrStb,
  output logic                      sysRdStb
);

  assign sysAddr  = {cpuAddr, 1'b0};
  assign sysRdStb = ctl.rdPhase & (|ctl.laneSel);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // System lane i pairs with processor lane (LANES-1-i): big-endian swap.
    localparam int C = LANES - 1 - i;
    logic sysEn;
    logic cpuEn;

    assign sysEn = ctl.wrDrive & ctl.laneSel[i];
    assign cpuEn = ctl.rdPhase & ctl.laneSel[i];

    assign sysWrStb[i]     = ctl.wrPhase & ctl.laneSel[i];
    assign sysDataOutEn[i] = sysEn;
    assign cpuDataOutEn[C] = cpuEn;

    assign sysDataOut[i*LANE_W +: LANE_W] =
      sysEn ? cpuDataIn[C*LANE_W +: LANE_W] : '0;
    assign cpuDataOut[C*LANE_W +: LANE_W] =
      cpuEn ? sysDataIn[i*LANE_W +: LANE_W] : '0;
  end

  // R8: a lane is never driven toward both sides at once
  a_r8_one_direction: assert property (@(posedge clk) disable iff (rst)
    !((|sysDataOutEn) && (|cpuDataOutEn)));

  // R5: write and read strobes are exclusive
  a_r5_wr_excl_rd: assert property (@(posedge clk) disable iff (rst)
    !((|sysWrStb) && sysRdStb));

endmodule

// File: rtl/laneBridge.sv
module laneBridge
  import laneBridgePkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-2:0]       cpuAddr,
  input  logic                    cpuRdWr,
  input  logic                    cpuAddrStbN,
  input  logic                    cpuUpperStbN,
  input  logic                    cpuLowerStbN,
  input  logic [LANES*LANE_W-1:0] cpuDataIn,
  output logic [LANES*LANE_W-1:0] cpuDataOut,
  output logic [LANES-1:0]        cpuDataOutEn,
  output logic                    cpuAckN,
  output logic [ADDR_W-1:0]       sysAddr,
  output logic [LANES*LANE_W-1:0] sysDataOut,
  output logic [LANES-1:0]        sysDataOutEn,
  input  logic [LANES*LANE_W-1:0] sysDataIn,
  output logic [LANES-1:0]        sysWrStb,
  output logic                    sysRdStb,
  input  logic                    sysReady
);

  laneCtl_t ctl;

  bridgeCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst(rst),
    .cpuAddrStbN(cpuAddrStbN), .cpuUpperStbN(cpuUpperStbN),
    .cpuLowerStbN(cpuLowerStbN), .cpuRdWr(cpuRdWr),
    .sysReady(sysReady), .ctl(ctl), .cpuAckN(cpuAckN)
  );

  bridgeDatapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl),
    .cpuAddr(cpuAddr), .cpuDataIn(cpuDataIn),
    .cpuDataOut(cpuDataOut), .cpuDataOutEn(cpuDataOutEn),
    .sysAddr(sysAddr), .sysDataOut(sysDataOut),
    .sysDataOutEn(sysDataOutEn), .sysDataIn(sysDataIn),
    .sysWrStb(sysWrStb), .sysRdStb(sysRdStb)
  );

  // R4: acknowledge only ever falls right after ready was seen
  a_r4_ack_after_ready: assert property (@(posedge clk) disable iff (rst)
    $fell(cpuAckN) |-> $past(sysReady));

  // R5: no write strobe while the acknowledge is out
  a_r5_no_write_in_done: assert property (@(posedge clk) disable iff (rst)
    !cpuAckN |-> (sysWrStb == '0));

endmodule

// File: tb/laneBridge_tb_top.sv
module laneBridge_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [22:0] cpuAddr = '0;
  logic        cpuRdWr = 1'b1;
  logic        cpuAddrStbN = 1'b1;
  logic        cpuUpperStbN = 1'b1;
  logic        cpuLowerStbN = 1'b1;
  logic [15:0] cpuDataIn = '0;
  logic [15:0] cpuDataOut;
  logic [1:0]  cpuDataOutEn;
  logic        cpuAckN;
  logic [23:0] sysAddr;
  logic [15:0] sysDataOut;
  logic [1:0]  sysDataOutEn;
  logic [15:0] sysDataIn;
  logic [1:0]  sysWrStb;
  logic        sysRdStb;
  logic        sysReady;

  int vecs = 0;
  int errs = 0;
  logic readyEn = 1'b1;
  logic [7:0] mem [0:255];

  always #10 clk = ~clk;

  laneBridge dut_i (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuRdWr(cpuRdWr),
    .cpuAddrStbN(cpuAddrStbN), .cpuUpperStbN(cpuUpperStbN),
    .cpuLowerStbN(cpuLowerStbN), .cpuDataIn(cpuDataIn),
    .cpuDataOut(cpuDataOut), .cpuDataOutEn(cpuDataOutEn), .cpuAckN(cpuAckN),
    .sysAddr(sysAddr), .sysDataOut(sysDataOut), .sysDataOutEn(sysDataOutEn),
    .sysDataIn(sysDataIn), .sysWrStb(sysWrStb), .sysRdStb(sysRdStb),
    .sysReady(sysReady)
  );

  // Byte-lane memory model: lane i is the byte at address offset i.
  assign sysDataIn = {mem[{sysAddr[7:1], 1'b1}], mem[{sysAddr[7:1], 1'b0}]};
  assign sysReady  = readyEn & (sysRdStb | (|sysWrStb));

  always @(posedge clk) begin
    if (sysWrStb[0]) mem[{sysAddr[7:1], 1'b0}] <= sysDataOut[7:0];
    if (sysWrStb[1]) mem[{sysAddr[7:1], 1'b1}] <= sysDataOut[15:8];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One full processor cycle; snapshots outputs while acknowledge is low.
  task automatic cpuCycle(input logic [23:0] byteAddr, input logic rd,
                          input logic upN, input logic loN, input logic [15:0] wdat,
                          output logic [15:0] rdat, output logic [1:0] cpuEn,
                          output logic [1:0] sysEn, output logic [15:0] sysOut,
                          output logic [23:0] addrSeen);
    @(negedge clk);
    cpuAddr = byteAddr[23:1]; cpuRdWr = rd; cpuDataIn = wdat;
    cpuUpperStbN = upN; cpuLowerStbN = loN; cpuAddrStbN = 1'b0;
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      if (!cpuAckN) break;
    end
    check("R3 ack arrives", {31'd0, cpuAckN}, 32'd0);
    rdat = cpuDataOut; cpuEn = cpuDataOutEn; sysEn = sysDataOutEn;
    sysOut = sysDataOut; addrSeen = sysAddr;
    cpuAddrStbN = 1'b1; cpuUpperStbN = 1'b1; cpuLowerStbN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check("R10 ack high", {31'd0, cpuAckN}, 32'd1);
    check("R10 strobes idle", {29'd0, sysWrStb, sysRdStb}, 32'd0);
    check("R10 enables idle", {28'd0, sysDataOutEn, cpuDataOutEn}, 32'd0);
  endtask

  task automatic testSyncAndStall();
    readyEn = 1'b0;
    @(negedge clk);
    cpuAddr = 23'h1800; cpuRdWr = 1'b0; cpuDataIn = 16'h5A00;
    cpuUpperStbN = 1'b0; cpuLowerStbN = 1'b1; cpuAddrStbN = 1'b0;
    @(negedge clk); check("R2 no strobe after edge 1", {30'd0, sysWrStb}, 32'd0);
    @(negedge clk); check("R2 no strobe after edge 2", {30'd0, sysWrStb}, 32'd0);
    @(negedge clk); check("R2 strobe after edge 3", {30'd0, sysWrStb}, 32'd1);
    check("R1 address", {8'd0, sysAddr}, 32'h3000);
    check("R7 upper to lane 0", {16'd0, sysDataOut}, 32'h005A);
    check("R8 only lane 0 enabled", {30'd0, sysDataOutEn}, 32'd1);
    repeat (20) @(negedge clk);
    check("R3 stalled ack high", {31'd0, cpuAckN}, 32'd1);
    check("R3 stalled strobe held", {30'd0, sysWrStb}, 32'd1);
    readyEn = 1'b1;
    @(negedge clk);
    check("R4 ack in DONE", {31'd0, cpuAckN}, 32'd0);
    check("R5 no write strobe in DONE", {30'd0, sysWrStb}, 32'd0);
    check("R8 lane held in DONE", {30'd0, sysDataOutEn}, 32'd1);
    cpuAddrStbN = 1'b1; cpuUpperStbN = 1'b1;
    @(negedge clk); check("R4 ack held edge 1", {31'd0, cpuAckN}, 32'd0);
    @(negedge clk); check("R4 ack held edge 2", {31'd0, cpuAckN}, 32'd0);
    @(negedge clk); check("R2 ack released edge 3", {31'd0, cpuAckN}, 32'd1);
    check("R5 byte written", {24'd0, mem[8'h00]}, 32'h5A);
  endtask

  task automatic testBytePair();
    logic [15:0] rd; logic [1:0] ce, se; logic [15:0] so; logic [23:0] a;
    cpuCycle(24'h3000, 1'b0, 1'b0, 1'b1, 16'hAB00, rd, ce, se, so, a);
    check("R8 even write lane", {30'd0, se}, 32'd1);
    cpuCycle(24'h3001, 1'b0, 1'b1, 1'b0, 16'h00CD, rd, ce, se, so, a);
    check("R8 odd write lane", {30'd0, se}, 32'd2);
    check("R7 lower to lane 1", {16'd0, so}, 32'hCD00);
    check("R1 odd byte address bit 0 low", {8'd0, a}, 32'h3000);
    cpuCycle(24'h3000, 1'b1, 1'b0, 1'b0, 16'h0000, rd, ce, se, so, a);
    check("R9 word read rejoins", {16'd0, rd}, 32'hABCD);
    check("R8 word read both lanes", {30'd0, ce}, 32'd3);
    cpuCycle(24'h3000, 1'b1, 1'b0, 1'b1, 16'h0000, rd, ce, se, so, a);
    check("R8 upper read masked", {16'd0, rd}, 32'hAB00);
    check("R8 upper read lane", {30'd0, ce}, 32'd2);
    cpuCycle(24'h3001, 1'b1, 1'b1, 1'b0, 16'h0000, rd, ce, se, so, a);
    check("R8 lower read masked", {16'd0, rd}, 32'h00CD);
    check("R6 read with no sys enable", {30'd0, se}, 32'd0);
  endtask

  task automatic testWordWrite();
    logic [15:0] rd; logic [1:0] ce, se; logic [15:0] so; logic [23:0] a;
    cpuCycle(24'h3010, 1'b0, 1'b0, 1'b0, 16'h1234, rd, ce, se, so, a);
    check("R7 word write swapped", {16'd0, so}, 32'h3412);
    check("R8 word write lanes", {30'd0, se}, 32'd3);
    check("R7 even byte in memory", {24'd0, mem[8'h10]}, 32'h12);
    check("R7 odd byte in memory", {24'd0, mem[8'h11]}, 32'h34);
    cpuCycle(24'h3010, 1'b1, 1'b0, 1'b0, 16'h0000, rd, ce, se, so, a);
    check("R7 word read back", {16'd0, rd}, 32'h1234);
  endtask

  task automatic testNoDataStrobe();
    readyEn = 1'b1;
    @(negedge clk);
    cpuAddr = 23'h1808; cpuRdWr = 1'b1; cpuAddrStbN = 1'b0;
    cpuUpperStbN = 1'b1; cpuLowerStbN = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 no read strobe without lanes", {31'd0, sysRdStb}, 32'd0);
    check("R6 no processor lanes", {30'd0, cpuDataOutEn}, 32'd0);
    check("R3 no ack without transfer", {31'd0, cpuAckN}, 32'd1);
    cpuRdWr = 1'b0;
    @(negedge clk);
    check("R5 no write strobe without lanes", {30'd0, sysWrStb}, 32'd0);
    check("R8 no system lanes", {30'd0, sysDataOutEn}, 32'd0);
    cpuUpperStbN = 1'b0; cpuRdWr = 1'b1;
    @(negedge clk);
    check("R6 read strobe once lane asked", {31'd0, sysRdStb}, 32'd1);
    cpuAddrStbN = 1'b1; cpuUpperStbN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic testResetMidCycle();
    readyEn = 1'b0;
    @(negedge clk);
    cpuAddr = 23'h1800; cpuRdWr = 1'b1; cpuAddrStbN = 1'b0;
    cpuUpperStbN = 1'b0; cpuLowerStbN = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 read strobe in ACTIVE", {31'd0, sysRdStb}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears read strobe", {31'd0, sysRdStb}, 32'd0);
    check("R10 reset clears lanes", {30'd0, cpuDataOutEn}, 32'd0);
    check("R10 reset ack high", {31'd0, cpuAckN}, 32'd1);
    cpuAddrStbN = 1'b1; cpuUpperStbN = 1'b1; cpuLowerStbN = 1'b1;
    @(negedge clk);
    rst = 1'b0; readyEn = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 no spurious cycle", {31'd0, sysRdStb}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    testSyncAndStall();
    testBytePair();
    testWordWrite();
    testNoDataStrobe();
    testResetMidCycle();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule